// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core from normal execution into an exception handler. When the core raises a start pulse with an 8-bit vector number, it supplies the current program counter, the five condition flags and the three-bit interrupt mask. The sequencer packs these fields into a 16-bit status word. The packed word uses the supervisor bit that was in force before entry. If the core was running in user mode, the sequencer switches to the supervisor stack. It then stores a return frame on that stack through a 16-bit memory port, and fetches the handler address from a table of longwords. When the handler address is ready, it gives one done pulse together with the new program counter. With each exception it also reports a fixed cycle cost, which depends on the class of the vector.

The block owns the supervisor bit and both stack pointers. The active stack pointer is A7. The other pointer is kept as the alternate. The core reports each newly loaded status word through a load strobe and that word's supervisor bit. Whenever the supervisor bit changes, the two pointers trade places.

The memory port carries one 16-bit word per transfer. The address is a byte address. A request stays raised and unchanged until an acknowledge pulse completes it.

Top module: `exc_entry_seq`

## Requirements
- R1: The pushed status word has the supervisor bit taken before entry at bit 13, the interrupt mask at bits 10:8, and flags X, N, Z, V, C at bits 4, 3, 2, 1, 0 (the flag input holds them in that order, X at its bit 4). Every other bit is zero.
- R2: On entry from user mode, the alternate pointer receives the old A7 and A7 takes the old alternate value. After any entry the supervisor bit is 1.
- R3: The frame is three word writes, made in this order: PC bits 31:16 at A7-4, PC bits 15:0 at A7-2, and the status word at A7-6. A7 here is the value after any mode switch. A7 ends 6 below that value, and all transfer addresses are even.
- R4: After the frame, two word reads are made, at byte address 4·vector and then 4·vector+2. The new PC is the first word followed by the second. done_o is high for exactly one cycle, while new_pc_o holds that value and busy_o is low.
- R5: The cost is taken from the vector number and is valid at done:
  - 50 for vectors 2 and 3;
  - 34 for vector 4 and for vectors 7 to 11;
  - 38 for vector 5;
  - 40 for vector 6;
  - 48 for vectors 24 to 31;
  - 30 for vectors 32 to 47;
  - 4 for any other vector below 64;
  - 56 for vectors 64 and above.
- R6: A status load that takes the supervisor bit from 1 to 0 exchanges A7 and the alternate pointer. A7 then holds the user pointer.
- R7: A status load that takes the supervisor bit from 0 to 1 exchanges A7 and the alternate pointer.
- R8: A status load that leaves the supervisor bit unchanged alters neither pointer.
- R9: While busy, start and status loads are ignored. The running sequence completes unchanged, and no second sequence follows.
- R10: After reset the block is idle, with no request, no done pulse, the supervisor bit set, A7 equal to RST_SSP and the alternate pointer equal to RST_USP.
- R11: A raised memory request holds its address, direction and write data until the cycle after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin exception entry (taken when idle) |
| vector_i | input | VW | Exception vector number |
| pc_i | input | 32 | Program counter to save |
| ccr_i | input | 5 | Flags X,N,Z,V,C at bits 4..0 |
| imask_i | input | 3 | Interrupt mask |
| sr_load_i | input | 1 | A new status word has been loaded |
| new_sup_i | input | 1 | Supervisor bit of that new status word |
| mem_req_o | output | 1 | Transfer request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mem_ack_i | input | 1 | One-cycle completion of the current transfer |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: new_pc_o is valid |
| new_pc_o | output | 32 | Handler address |
| cost_o | output | CW | Cycle cost of the current exception |
| sup_o | output | 1 | Supervisor bit |
| a7_o | output | 32 | Active stack pointer |
| alt_sp_o | output | 32 | Inactive stack pointer |

## Verification
The assertions assume that the memory answers a raised request with exactly one acknowledge pulse. They also assume the acknowledge is never given while no request is pending, or in the cycle right after a previous acknowledge. The bench memory model respects this: it acknowledges only when it sees a request while its own acknowledge is low. It inserts a wait of zero to two cycles that varies from one exception to the next. Every vector number is swept, with user-mode entries and status loads mixed in. Stray start and load pulses are driven only in the busy window that the R9 check targets.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 2 * WORD_W;
    localparam int SR_SUP_BIT  = 13;
    localparam int SR_MASK_LSB = 8;
    localparam int MASK_W      = 3;
    localparam int CCR_W       = 5;

    // cycle costs per exception class
    localparam int COST_BUSERR = 50;
    localparam int COST_STD    = 34;
    localparam int COST_DIVZ   = 38;
    localparam int COST_CHK    = 40;
    localparam int COST_IRQ    = 48;
    localparam int COST_TRAP   = 30;
    localparam int COST_LOW    = 4;
    localparam int COST_HIGH   = 56;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PC_HI,
        ST_PC_LO,
        ST_SR,
        ST_VEC_HI,
        ST_VEC_LO
    } seq_state_e;

    function automatic logic [WORD_W-1:0] pack_status(
        input logic              sup,
        input logic [MASK_W-1:0] mask,
        input logic [CCR_W-1:0]  ccr
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[SR_SUP_BIT] = sup;
        w[SR_MASK_LSB +: MASK_W] = mask;
        w[CCR_W-1:0] = ccr;
        return w;
    endfunction
endpackage

// File: rtl/exc_cost_lut.sv
module exc_cost_lut
    import exc_seq_pkg::*;
#(
    parameter int VW = 8,
    parameter int CW = 8
) (
    input  logic [VW-1:0] vec_i,
    output logic [CW-1:0] cost_o
);
    logic [31:0] vn;
    int          c;

    always_comb begin
        vn = 32'(vec_i);
        if (vn == 32'd2 || vn == 32'd3)        c = COST_BUSERR;
        else if (vn == 32'd4)                  c = COST_STD;
        else if (vn == 32'd5)                  c = COST_DIVZ;
        else if (vn == 32'd6)                  c = COST_CHK;
        else if (vn >= 32'd7 && vn <= 32'd11)  c = COST_STD;
        else if (vn >= 32'd24 && vn <= 32'd31) c = COST_IRQ;
        else if (vn >= 32'd32 && vn <= 32'd47) c = COST_TRAP;
        else if (vn < 32'd64)                  c = COST_LOW;
        else                                   c = COST_HIGH;
        cost_o = CW'(c);
    end
endmodule

// File: rtl/exc_sp_bank.sv
module exc_sp_bank #(
    parameter int              AW      = 32,
    parameter logic [AW-1:0]   RST_SSP = '0,
    parameter logic [AW-1:0]   RST_USP = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap_i,
    input  logic          sup_we_i,
    input  logic          sup_val_i,
    input  logic [AW-1:0] dec_i,
    output logic          sup_o,
    output logic [AW-1:0] a7_o,
    output logic [AW-1:0] alt_o
);
    typedef struct packed {
        logic          sup;
        logic [AW-1:0] a7;
        logic [AW-1:0] alt;
    } sp_t;

    sp_t q, d;

    always_comb begin
        d = q;
        if (swap_i) begin
            d.a7  = q.alt;
            d.alt = q.a7;
        end
        d.a7 = d.a7 - dec_i;
        if (sup_we_i) d.sup = sup_val_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sup <= 1'b1;
            q.a7  <= RST_SSP;
            q.alt <= RST_USP;
        end else begin
            q <= d;
        end
    end

    assign sup_o = q.sup;
    assign a7_o  = q.a7;
    assign alt_o = q.alt;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int                 VW      = 8,
    parameter int                 CW      = 8,
    parameter logic [ADDR_W-1:0]  RST_SSP = 32'h0000_0800,
    parameter logic [ADDR_W-1:0]  RST_USP = 32'h0000_0700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VW-1:0]     vector_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [MASK_W-1:0] imask_i,
    input  logic              sr_load_i,
    input  logic              new_sup_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] new_pc_o,
    output logic [CW-1:0]     cost_o,
    output logic              sup_o,
    output logic [ADDR_W-1:0] a7_o,
    output logic [ADDR_W-1:0] alt_sp_o
);
    localparam logic [ADDR_W-1:0] PC_FRAME = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] SR_FRAME = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_W / 8);

    typedef struct packed {
        seq_state_e        state;
        logic [VW-1:0]     vec;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] hi;
        logic [ADDR_W-1:0] new_pc;
        logic [CW-1:0]     cost;
        logic              done;
    } seq_t;

    seq_t q, d;

    logic              sp_swap, sp_sup_we, sp_sup_val;
    logic [ADDR_W-1:0] sp_dec;
    logic              sup_w;
    logic [ADDR_W-1:0] a7_w, alt_w;
    logic [CW-1:0]     lut_cost;
    logic [ADDR_W-1:0] vec_addr;

    exc_cost_lut #(.VW(VW), .CW(CW)) u_cost (
        .vec_i  (vector_i),
        .cost_o (lut_cost)
    );

    exc_sp_bank #(.AW(ADDR_W), .RST_SSP(RST_SSP), .RST_USP(RST_USP)) u_sp (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap_i    (sp_swap),
        .sup_we_i  (sp_sup_we),
        .sup_val_i (sp_sup_val),
        .dec_i     (sp_dec),
        .sup_o     (sup_w),
        .a7_o      (a7_w),
        .alt_o     (alt_w)
    );

    assign vec_addr = ADDR_W'({q.vec, 2'b00});

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        sp_swap    = 1'b0;
        sp_sup_we  = 1'b0;
        sp_sup_val = 1'b0;
        sp_dec     = '0;
        mem_req_o  = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        mem_wdata_o = '0;

        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.vec      = vector_i;
                    d.pc       = pc_i;
                    d.sr       = pack_status(sup_w, imask_i, ccr_i);
                    d.cost     = lut_cost;
                    d.state    = ST_PC_HI;
                    sp_swap    = !sup_w;
                    sp_sup_we  = 1'b1;
                    sp_sup_val = 1'b1;
                    sp_dec     = PC_FRAME;
                end else if (sr_load_i) begin
                    sp_swap    = new_sup_i ^ sup_w;
                    sp_sup_we  = 1'b1;
                    sp_sup_val = new_sup_i;
                end
            end
            ST_PC_HI: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = a7_w;
                mem_wdata_o = q.pc[ADDR_W-1:WORD_W];
                if (mem_ack_i) d.state = ST_PC_LO;
            end
            ST_PC_LO: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = a7_w + WORD_STEP;
                mem_wdata_o = q.pc[WORD_W-1:0];
                if (mem_ack_i) begin
                    d.state = ST_SR;
                    sp_dec  = SR_FRAME;
                end
            end
            ST_SR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = a7_w;
                mem_wdata_o = q.sr;
                if (mem_ack_i) d.state = ST_VEC_HI;
            end
            ST_VEC_HI: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr;
                if (mem_ack_i) begin
                    d.hi    = mem_rdata_i;
                    d.state = ST_VEC_LO;
                end
            end
            ST_VEC_LO: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr + WORD_STEP;
                if (mem_ack_i) begin
                    d.new_pc = {q.hi, mem_rdata_i};
                    d.done   = 1'b1;
                    d.state  = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.vec    <= '0;
            q.pc     <= '0;
            q.sr     <= '0;
            q.hi     <= '0;
            q.new_pc <= '0;
            q.cost   <= '0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.state != ST_IDLE);
    assign done_o   = q.done;
    assign new_pc_o = q.new_pc;
    assign cost_o   = q.cost;
    assign sup_o    = sup_w;
    assign a7_o     = a7_w;
    assign alt_sp_o = alt_w;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int VW = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic [15:0] mem_wdata_o,
    input logic        mem_ack_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        sup_o
);
    // R4: done lasts a single cycle
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4: done arrives when the sequence has gone idle
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2: after every entry the core is in supervisor mode
    assert_done_sup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> sup_o);

    // R11: request held steady until acknowledged
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R3: transfers are word aligned
    assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !mem_addr_o[0]);

    // R4: reads stay inside the vector table
    assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |-> ((mem_addr_o >> (VW + 2)) == 32'd0));

    // R9: mode cannot change while a sequence runs
    assert_busy_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(sup_o));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.VW(VW)) u_chk (.*);

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    localparam logic [31:0] SSP0 = 32'h0000_0800;
    localparam logic [31:0] USP0 = 32'h0000_0700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  vector_i = '0;
    logic [31:0] pc_i = '0;
    logic [4:0]  ccr_i = '0;
    logic [2:0]  imask_i = '0;
    logic        sr_load_i = 1'b0;
    logic        new_sup_i = 1'b0;
    logic        mem_req_o, mem_we_o;
    logic [31:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i;
    logic        mem_ack_i;
    logic        busy_o, done_o, sup_o;
    logic [31:0] new_pc_o, a7_o, alt_sp_o;
    logic [7:0]  cost_o;

    exc_entry_seq #(.VW(8), .CW(8), .RST_SSP(SSP0), .RST_USP(USP0)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vector_i(vector_i),
        .pc_i(pc_i), .ccr_i(ccr_i), .imask_i(imask_i), .sr_load_i(sr_load_i),
        .new_sup_i(new_sup_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .busy_o(busy_o),
        .done_o(done_o), .new_pc_o(new_pc_o), .cost_o(cost_o), .sup_o(sup_o),
        .a7_o(a7_o), .alt_sp_o(alt_sp_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;
    int xfer_cnt = 0;
    logic        log_we   [8];
    logic [31:0] log_addr [8];
    logic [15:0] log_data [8];

    // memory responder: one acknowledge per request, variable wait
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
            wcnt        <= 0;
        end else begin
            mem_ack_i <= 1'b0;
            if (mem_req_o && !mem_ack_i) begin
                if (wcnt >= lat) begin
                    mem_ack_i   <= 1'b1;
                    mem_rdata_i <= mem_addr_o[15:0] ^ 16'h5A3C;
                    wcnt        <= 0;
                    log_we[xfer_cnt % 8]   <= mem_we_o;
                    log_addr[xfer_cnt % 8] <= mem_addr_o;
                    log_data[xfer_cnt % 8] <= mem_we_o ? mem_wdata_o
                                                       : (mem_addr_o[15:0] ^ 16'h5A3C);
                    xfer_cnt <= xfer_cnt + 1;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [7:0] exp_cost(input int v);
        if (v == 2 || v == 3) return 8'd50;
        if (v == 4) return 8'd34;
        if (v == 5) return 8'd38;
        if (v == 6) return 8'd40;
        if (v >= 7 && v <= 11) return 8'd34;
        if (v >= 24 && v <= 31) return 8'd48;
        if (v >= 32 && v <= 47) return 8'd30;
        if (v < 64) return 8'd4;
        return 8'd56;
    endfunction

    logic        e_sup;
    logic [31:0] e_a7, e_alt;

    task automatic load_sup(input logic s, input string tag);
        logic [31:0] t;
        @(negedge clk);
        sr_load_i = 1'b1;
        new_sup_i = s;
        @(negedge clk);
        sr_load_i = 1'b0;
        if (s != e_sup) begin
            t = e_a7; e_a7 = e_alt; e_alt = t;
        end
        e_sup = s;
        chk({tag, " sup"}, 32'(sup_o), 32'(e_sup));
        chk({tag, " a7"}, a7_o, e_a7);
        chk({tag, " alt"}, alt_sp_o, e_alt);
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic run_exc(input int v, input bit stray);
        logic [31:0] pc, base, vb;
        logic [2:0]  m;
        logic [4:0]  c;
        logic [15:0] sr;
        logic [31:0] ea [5];
        logic [15:0] ed [5];
        logic        ew [5];
        bit          was_user, seen;
        int          x0;
        pc = {v[7:0], ~v[7:0], 8'h12, v[7:0] ^ 8'hA5};
        m  = 3'(v >> 5);
        c  = 5'(v ^ (v >> 3));
        sr = 16'h0000;
        sr[13] = e_sup;
        sr[10:8] = m;
        sr[4:0] = c;
        was_user = !e_sup;
        if (was_user) begin
            base = e_alt; e_alt = e_a7;
        end else begin
            base = e_a7;
        end
        e_sup = 1'b1;
        e_a7  = base - 32'd6;
        vb = 32'(v) * 4;
        ew[0] = 1; ea[0] = base - 4; ed[0] = pc[31:16];
        ew[1] = 1; ea[1] = base - 2; ed[1] = pc[15:0];
        ew[2] = 1; ea[2] = base - 6; ed[2] = sr;
        ew[3] = 0; ea[3] = vb;       ed[3] = vb[15:0] ^ 16'h5A3C;
        ew[4] = 0; ea[4] = vb + 2;   ed[4] = (vb[15:0] + 16'd2) ^ 16'h5A3C;
        x0 = xfer_cnt;
        @(negedge clk);
        vector_i = 8'(v); pc_i = pc; imask_i = m; ccr_i = c;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (stray) begin
            @(negedge clk);
            @(negedge clk);
            start_i = 1'b1; vector_i = 8'(v + 1); sr_load_i = 1'b1; new_sup_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0; sr_load_i = 1'b0;
        end
        wait_done(seen);
        chk("R4 done seen", 32'(seen), 32'd1);
        chk("R4 new pc", new_pc_o, {ed[3], ed[4]});
        chk("R4 busy low at done", 32'(busy_o), 32'd0);
        chk("R5 cost", 32'(cost_o), 32'(exp_cost(v)));
        chk("R3 transfer count", 32'(xfer_cnt - x0), 32'd5);
        for (int k = 0; k < 5; k++) begin
            chk((k < 3) ? "R3 dir" : "R4 dir", 32'(log_we[(x0 + k) % 8]), 32'(ew[k]));
            chk((k < 3) ? "R3 addr" : "R4 addr", log_addr[(x0 + k) % 8], ea[k]);
            chk((k == 2) ? "R1 status word" : ((k < 3) ? "R3 data" : "R4 data"),
                32'(log_data[(x0 + k) % 8]), 32'(ed[k]));
        end
        chk("R3 a7 after", a7_o, e_a7);
        chk("R2 sup after", 32'(sup_o), 32'd1);
        chk(was_user ? "R2 user pointer saved" : "R2 alt unchanged", alt_sp_o, e_alt);
        @(negedge clk);
        chk("R4 done one cycle", 32'(done_o), 32'd0);
    endtask

    initial begin
        e_sup = 1'b1; e_a7 = SSP0; e_alt = USP0;
        for (int i = 0; i < 4; i++) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 busy", 32'(busy_o), 32'd0);
        chk("R10 done", 32'(done_o), 32'd0);
        chk("R10 req", 32'(mem_req_o), 32'd0);
        chk("R10 sup", 32'(sup_o), 32'd1);
        chk("R10 a7", a7_o, SSP0);
        chk("R10 alt", alt_sp_o, USP0);

        for (int v = 0; v < 256; v++) begin
            lat = v % 3;
            if (v % 4 == 1) begin
                load_sup(1'b0, "R6 to user");
                if (v % 8 == 5) begin
                    load_sup(1'b0, "R8 same mode");
                    load_sup(1'b1, "R7 to supervisor");
                    load_sup(1'b0, "R6 to user again");
                end
            end
            if (v % 16 == 2) load_sup(1'b1, "R8 stay supervisor");
            run_exc(v, 1'b0);
        end

        // R9: stray start and status load during a running sequence
        lat = 1;
        load_sup(1'b0, "R6 before busy test");
        run_exc(8, 1'b1);
        begin
            int xs;
            xs = xfer_cnt;
            for (int i = 0; i < 30; i++) @(negedge clk);
            chk("R9 no second sequence", 32'(xfer_cnt - xs), 32'd0);
            chk("R9 idle", 32'(busy_o), 32'd0);
            chk("R9 sup kept", 32'(sup_o), 32'd1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule